// File: doc/BRIEF.md
# Memory-to-Memory Fill and Copy Address Engine

This block drives the address side of a memory-to-memory transfer. Software loads a source address, a destination address and a byte count through a small register write port. It then writes the control register with the start bit set. The engine raises a bus request. Each time the bus is granted and a data beat completes, it steps the addresses by one word and takes four bytes off the count. The data path and the arbiter sit outside this block. The block sees them only through the grant and beat-done inputs and drives them through the two address outputs.

Two options shape a transfer. With constant-source set, the source address stays fixed while the destination walks forward, so one word is replicated across a run of destination words. Filling ten words therefore needs a count of 40. A bandwidth-control code picks a chunk size. Each time the remaining count first comes within 15 bytes above a multiple of that chunk, the engine withdraws its request for one cycle after the beat ends. This lets the arbiter hand the bus to another master, and the engine then requests again.

Top module: `m2m_fill_engine`

## Requirements
- R1: After a synchronous active-low reset, bus_req, busy, done and align_err are 0, and src_addr, dst_addr and bytes_left are 0.
- R2: A beat is accepted on a rising edge where busy, bus_req, bus_gnt and beat_done are all 1. After an accepted beat, dst_addr has grown by 4. When constant-source is clear, src_addr has also grown by 4.
- R3: When constant-source (control bit 1) is set, src_addr keeps its value across every beat of the transfer.
- R4: Each accepted beat lowers bytes_left by 4. The two low bits of a written count are dropped. No beat is accepted while bus_req or bus_gnt or beat_done is 0.
- R5: The beat that brings bytes_left to 0 clears busy and bus_req and sets done. A start with a zero count sets done at once and never raises bus_req.
- R6: A bandwidth code (control bits 7:4) of 0, or of 13 to 15, keeps bus_req at 1 from the start until the final beat.
- R7: For a code k from 1 to 12, the chunk size is C = 16 << (k-1) bytes. An accepted beat that leaves bytes_left non-zero with bytes_left mod C equal to 12 drops bus_req for exactly the next cycle. That value is the first entry into the 15-byte window above a multiple of C. bus_req returns to 1 in the cycle after.
- R8: A transfer whose starting count equals the chunk size starts with bus_req at 1. bus_req drops only after data has moved.
- R9: A start with constant-source set and bits 1:0 of src_addr or dst_addr non-zero sets align_err, leaves busy at 0 and keeps bus_req at 0. The next accepted start clears align_err.
- R10: Register writes of any kind are ignored while busy is 1.
- R11: Register offset 0 loads the source address, 1 the destination address, 2 the byte count and 3 the control word. Control bit 0 is start, bit 1 is constant-source and bits 7:4 are the bandwidth code. A start attempt clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register offset |
| cfg_wdata | input | ADDR_W | Register write data |
| bus_gnt | input | 1 | Bus granted to this engine |
| beat_done | input | 1 | Current bus cycle (one word) ends |
| bus_req | output | 1 | Bus request |
| src_addr | output | ADDR_W | Current source address |
| dst_addr | output | ADDR_W | Current destination address |
| bytes_left | output | CNT_W | Remaining byte count |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer completed |
| align_err | output | 1 | Start refused for misalignment |

## Verification
The bench builds the engine with its defaults: 32-bit addresses, a 16-bit count and twelve chunk levels starting at 16 bytes. With these values every bandwidth code, from the 16-byte chunk up to the 32 KiB one, decodes within the count's range. Counts of a few hundred bytes cross several 16-, 32- and 64-byte chunk boundaries, which exercises the release rule often. The largest chunks confirm that no release occurs on short transfers. Random grant and beat patterns, together with unused codes 13 to 15, check that beats are only taken while the request is up.

// File: rtl/m2m_pkg.sv
// Shared register offsets and control-word bit positions for the fill engine.
// Assumes a 2-bit register select.
package m2m_pkg;
    typedef enum logic [1:0] {
        SEL_SRC = 2'd0,
        SEL_DST = 2'd1,
        SEL_CNT = 2'd2,
        SEL_CTL = 2'd3
    } reg_sel_e;

    localparam int CTL_START_BIT = 0;
    localparam int CTL_CONST_BIT = 1;
    localparam int CTL_BWC_LSB   = 4;
    localparam int BWC_W         = 4;
endpackage

// File: rtl/m2m_chunk_decode.sv
// Turns a bandwidth code into a chunk mask (chunk size minus one).
// Code k in 1..NUM_LEVELS gives a chunk of 2**(BASE_SHIFT+k-1) bytes.
// Assumes CNT_W > BASE_SHIFT+NUM_LEVELS-1. All other codes disable release.
module m2m_chunk_decode #(
    parameter int CNT_W      = 16,
    parameter int NUM_LEVELS = 12,
    parameter int BASE_SHIFT = 4
) (
    input  logic [m2m_pkg::BWC_W-1:0] code,
    output logic                      rel_en,
    output logic [CNT_W-1:0]          chunk_mask
);
    // Selects the mask for the matching level, one candidate per level.
    always_comb begin
        rel_en     = 1'b0;
        chunk_mask = '0;
        for (int k = 1; k <= NUM_LEVELS; k++) begin
            if (code == m2m_pkg::BWC_W'(k)) begin
                rel_en     = 1'b1;
                chunk_mask = (CNT_W'(1) << (BASE_SHIFT + k - 1)) - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/m2m_addr_gen.sv
// Holds the source, destination and byte-count registers.
// Loads them from the write port when idle and steps them once per accepted beat.
// Assumes the caller blocks writes while a transfer runs.
module m2m_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              step,
    input  logic              const_src,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  cnt_next
);
    import m2m_pkg::*;

    localparam logic [ADDR_W-1:0] WORD_A = ADDR_W'(4);
    localparam logic [CNT_W-1:0]  WORD_C = CNT_W'(4);

    assign cnt_next = cnt_q - WORD_C;

    // Loads registers on writes and advances them on beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_SRC: src_q <= wr_data;
                SEL_DST: dst_q <= wr_data;
                SEL_CNT: cnt_q <= wr_data[CNT_W-1:0] & ~CNT_W'(3);
                default: ;
            endcase
        end else if (step) begin
            dst_q <= dst_q + WORD_A;
            cnt_q <= cnt_next;
            if (!const_src) src_q <= src_q + WORD_A;
        end
    end

    // R3
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && const_src) |=> $stable(src_q));
    // R2
    dst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (dst_q == $past(dst_q) + WORD_A));
    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (cnt_q == $past(cnt_q) - WORD_C));
endmodule

// File: rtl/m2m_req_ctrl.sv
// Start checking, busy/done/error state and the bus request with release.
// Assumes the count moves in whole words and that beat_done marks the end of a bus cycle.
module m2m_req_ctrl #(
    parameter int CNT_W      = 16,
    parameter int BASE_SHIFT = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ctl_wr,
    input  logic                      start_bit,
    input  logic                      const_in,
    input  logic [m2m_pkg::BWC_W-1:0] bwc_in,
    input  logic [1:0]                src_lo,
    input  logic [1:0]                dst_lo,
    input  logic [CNT_W-1:0]          cnt_q,
    input  logic [CNT_W-1:0]          cnt_next,
    input  logic                      rel_en,
    input  logic [CNT_W-1:0]          chunk_mask,
    input  logic                      bus_gnt,
    input  logic                      beat_done,
    output logic                      bus_req,
    output logic                      step,
    output logic                      busy_q,
    output logic                      done_q,
    output logic                      err_q,
    output logic                      const_q,
    output logic [m2m_pkg::BWC_W-1:0] bwc_q
);
    // First count value inside the 15-byte window above a chunk multiple.
    localparam logic [CNT_W-1:0] WIN_ENTRY = CNT_W'((1 << BASE_SHIFT) - 4);

    logic rel_q;
    logic misaligned;
    logic rel_hit;

    assign bus_req    = busy_q && !rel_q;
    assign step       = bus_req && bus_gnt && beat_done;
    assign misaligned = const_in && ((src_lo | dst_lo) != 2'b00);
    assign rel_hit    = rel_en && (cnt_next != '0) && ((cnt_next & chunk_mask) == WIN_ENTRY);

    // Latches the mode fields and runs the start, beat and finish sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            rel_q   <= 1'b0;
            const_q <= 1'b0;
            bwc_q   <= '0;
        end else begin
            rel_q <= step && rel_hit;
            if (step && cnt_next == '0) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
            if (ctl_wr) begin
                const_q <= const_in;
                bwc_q   <= bwc_in;
                if (start_bit) begin
                    done_q <= 1'b0;
                    if (misaligned) begin
                        err_q <= 1'b1;
                    end else begin
                        err_q <= 1'b0;
                        if (cnt_q == '0) done_q <= 1'b1;
                        else             busy_q <= 1'b1;
                    end
                end
            end
        end
    end

    // R5
    req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !bus_req);
    // R7
    req_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !bus_req) |=> bus_req);
    // R9
    err_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !busy_q);
endmodule

// File: rtl/m2m_fill_engine.sv
// Top of the memory-to-memory address engine: register port, address stepping,
// constant-source fill and periodic bus release. Assumes writes are dropped while busy.
module m2m_fill_engine #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int NUM_LEVELS = 12,
    parameter int BASE_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              bus_gnt,
    input  logic              beat_done,
    output logic              bus_req,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CNT_W-1:0]  bytes_left,
    output logic              busy,
    output logic              done,
    output logic              align_err
);
    import m2m_pkg::*;

    logic              wr_ok;
    logic              ctl_wr;
    logic              step;
    logic              const_q;
    logic [BWC_W-1:0]  bwc_q;
    logic              rel_en;
    logic [CNT_W-1:0]  chunk_mask;
    logic [CNT_W-1:0]  cnt_next;

    // R10: writes only land while idle
    assign wr_ok  = cfg_we && !busy;
    assign ctl_wr = wr_ok && (reg_sel_e'(cfg_sel) == SEL_CTL);

    m2m_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_ok),
        .wr_sel    (cfg_sel),
        .wr_data   (cfg_wdata),
        .step      (step),
        .const_src (const_q),
        .src_q     (src_addr),
        .dst_q     (dst_addr),
        .cnt_q     (bytes_left),
        .cnt_next  (cnt_next)
    );

    m2m_chunk_decode #(.CNT_W(CNT_W), .NUM_LEVELS(NUM_LEVELS), .BASE_SHIFT(BASE_SHIFT)) u_dec (
        .code       (bwc_q),
        .rel_en     (rel_en),
        .chunk_mask (chunk_mask)
    );

    m2m_req_ctrl #(.CNT_W(CNT_W), .BASE_SHIFT(BASE_SHIFT)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .start_bit  (cfg_wdata[CTL_START_BIT]),
        .const_in   (cfg_wdata[CTL_CONST_BIT]),
        .bwc_in     (cfg_wdata[CTL_BWC_LSB +: BWC_W]),
        .src_lo     (src_addr[1:0]),
        .dst_lo     (dst_addr[1:0]),
        .cnt_q      (bytes_left),
        .cnt_next   (cnt_next),
        .rel_en     (rel_en),
        .chunk_mask (chunk_mask),
        .bus_gnt    (bus_gnt),
        .beat_done  (beat_done),
        .bus_req    (bus_req),
        .step       (step),
        .busy_q     (busy),
        .done_q     (done),
        .err_q      (align_err),
        .const_q    (const_q),
        .bwc_q      (bwc_q)
    );

    // R10
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_we && !(bus_gnt && beat_done)) |=> ($stable(src_addr) && $stable(bytes_left)));
endmodule

// File: tb/m2m_fill_engine_tb.sv
// Self-checking bench: directed corner cases plus seeded random transfers,
// compared every cycle against a reference model built from the requirements.
module m2m_fill_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        bus_gnt = 1'b0;
    logic        beat_done = 1'b0;
    logic        bus_req, busy, done, align_err;
    logic [31:0] src_addr, dst_addr;
    logic [15:0] bytes_left;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit chk_on = 1'b0;

    // reference model state
    logic [31:0] m_src, m_dst;
    logic [15:0] m_cnt;
    logic        m_busy, m_done, m_err, m_rel, m_const;
    logic [3:0]  m_bwc;

    m2m_fill_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .bus_gnt(bus_gnt), .beat_done(beat_done),
        .bus_req(bus_req), .src_addr(src_addr), .dst_addr(dst_addr),
        .bytes_left(bytes_left), .busy(busy), .done(done), .align_err(align_err)
    );

    always #10 clk = ~clk;

    // R7: release on the beat that leaves count mod chunk equal to 12
    function automatic bit rel_hit(input logic [3:0] code, input logic [15:0] n);
        int c;
        if (code == 0 || code > 12 || n == 0) return 1'b0;
        c = 16 << (code - 1);
        return (int'(n) % c) == 12;
    endfunction

    // Reference model of the requirements, advanced on each edge.
    always @(posedge clk) begin : model
        logic [15:0] nn;
        logic        bt;
        if (!rst_n) begin
            m_src <= 0; m_dst <= 0; m_cnt <= 0; m_busy <= 0; m_done <= 0;
            m_err <= 0; m_rel <= 0; m_const <= 0; m_bwc <= 0;
        end else begin
            bt = m_busy && !m_rel && bus_gnt && beat_done;
            nn = m_cnt - 16'd4;
            m_rel <= bt && rel_hit(m_bwc, nn);
            if (bt) begin
                m_dst <= m_dst + 4;
                if (!m_const) m_src <= m_src + 4;
                m_cnt <= nn;
                if (nn == 0) begin m_busy <= 0; m_done <= 1; end
            end
            if (cfg_we && !m_busy) begin
                case (cfg_sel)
                    2'd0: m_src <= cfg_wdata;
                    2'd1: m_dst <= cfg_wdata;
                    2'd2: m_cnt <= cfg_wdata[15:0] & 16'hFFFC;
                    default: begin
                        m_const <= cfg_wdata[1];
                        m_bwc   <= cfg_wdata[7:4];
                        if (cfg_wdata[0]) begin
                            m_done <= 0;
                            if (cfg_wdata[1] && ((m_src[1:0] | m_dst[1:0]) != 0)) m_err <= 1;
                            else begin
                                m_err <= 0;
                                if (m_cnt == 0) m_done <= 1;
                                else m_busy <= 1;
                            end
                        end
                    end
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 R3 src_addr", src_addr, m_src);
        chk("R2 dst_addr", dst_addr, m_dst);
        chk("R4 bytes_left", {16'd0, bytes_left}, {16'd0, m_cnt});
        chk("R5 R6 R7 R8 bus_req", {31'd0, bus_req}, {31'd0, m_busy && !m_rel});
        chk("R5 busy", {31'd0, busy}, {31'd0, m_busy});
        chk("R5 done", {31'd0, done}, {31'd0, m_done});
        chk("R9 align_err", {31'd0, align_err}, {31'd0, m_err});
    endtask

    task automatic tick();
        @(negedge clk);
        if (chk_on) compare_all();
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        tick();
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] n);
        wr(2'd0, s); wr(2'd1, d); wr(2'd2, n);
    endtask

    // Runs the bus with grant/beat probabilities (out of 10) until idle.
    task automatic run(input int gp, input int bp);
        int lim = 0;
        while ((busy || m_busy) && lim < 20000) begin
            tick();
            bus_gnt   = ($urandom % 10) < gp;
            beat_done = ($urandom % 10) < bp;
            lim++;
        end
        tick();
        bus_gnt = 1'b0; beat_done = 1'b0;
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 bus_req", {31'd0, bus_req}, 0);
        chk("R1 busy", {31'd0, busy}, 0);
        chk("R1 bytes_left", {16'd0, bytes_left}, 0);
        chk("R1 src_addr", src_addr, 0);
        chk_on = 1'b1;

        // R11 register decode
        setup(32'h0000_0100, 32'h0000_2000, 32'd40);
        chk("R11 dst load", dst_addr, 32'h0000_2000);
        // R3 fill ten words from one source word, no release
        wr(2'd3, 32'h0000_0003);
        run(10, 10);
        chk("R3 fill end dst", dst_addr, 32'h0000_2028);
        chk("R3 fill src held", src_addr, 32'h0000_0100);

        // R8 start count equals chunk (code 1, 16 bytes)
        setup(32'h0000_0400, 32'h0000_0800, 32'd16);
        wr(2'd3, 32'h0000_0011);
        chk("R8 request up before data", {31'd0, bus_req}, 1);
        run(10, 10);

        // R7 chunk 32, 100 bytes, normal copy
        setup(32'h0000_1000, 32'h0000_3000, 32'd100);
        wr(2'd3, 32'h0000_0021);
        run(10, 10);
        chk("R7 copy end src", src_addr, 32'h0000_1064);

        // R9 misaligned constant-source start refused, then cleared
        setup(32'h0000_0102, 32'h0000_0200, 32'd8);
        wr(2'd3, 32'h0000_0003);
        chk("R9 refused", {31'd0, align_err}, 1);
        chk("R9 not busy", {31'd0, busy}, 0);
        wr(2'd0, 32'h0000_0104);
        wr(2'd3, 32'h0000_0003);
        chk("R9 cleared", {31'd0, align_err}, 0);
        run(10, 10);

        // R5 zero count start
        wr(2'd2, 32'd0);
        wr(2'd3, 32'h0000_0001);
        chk("R5 zero count done", {31'd0, done}, 1);
        chk("R5 zero count no request", {31'd0, bus_req}, 0);

        // R4 low count bits dropped; R10 writes ignored while busy
        setup(32'h0000_5000, 32'h0000_6000, 32'h0000_002B);
        chk("R4 low bits dropped", {16'd0, bytes_left}, 32'd40);
        wr(2'd3, 32'h0000_0001);
        wr(2'd2, 32'd200);
        wr(2'd0, 32'h0000_7777);
        chk("R10 count kept", {16'd0, bytes_left}, 32'd40);
        chk("R10 src kept", src_addr, 32'h0000_5000);
        run(6, 5);

        // R6 unused code 14 behaves as no release
        setup(32'h0000_0000, 32'h0000_0100, 32'd96);
        wr(2'd3, 32'h0000_00E1);
        run(10, 10);

        // random transfers
        for (int t = 0; t < 60; t++) begin
            logic [31:0] s, d, n, ctl;
            s = {$urandom % 65536} << 2;
            d = {$urandom % 65536} << 2;
            if (($urandom % 6) == 0) s = s | 32'd1;
            n = $urandom % 420;
            ctl = {24'd0, 4'($urandom % 16), 2'b00, 1'($urandom % 2), 1'b1};
            setup(s, d, n);
            wr(2'd3, ctl);
            run(1 + int'($urandom % 10), 1 + int'($urandom % 10));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule